// File: doc/BRIEF.md
# Double-Buffered MIMO Channel Profile Loader

This block sits between a host word stream and a bank of fading-channel FIR filters. The filters of a 2×2 MIMO link (four sub-channels) need a fresh set of tap gains many times per second. The host streams those gains in as a complete profile. The filters must keep running from a steady, self-consistent coefficient set while that happens.

Two coefficient banks are kept. The active bank drives the filter-side gain bus. The host writes only into the other bank, the shadow. A periodic refresh tick marks each profile boundary. If the shadow holds a complete profile when the tick arrives, the two banks change roles, and all four sub-channels take their new gains on the same clock edge. If the shadow is still incomplete, the active coefficients stay in place and the shortfall is reported. Each sub-channel record opens with a header word. The header carries the sub-channel number so that a slipped or reordered stream can be detected.

Top module: `ppl_top`

## Requirements
- R1: After reset, every gain field reads zero, `wr_ready` is 1, and `commit`, `underrun` and `seq_err` are 0.
- R2: A profile is 40 accepted words: four records in sub-channel order 0,1,2,3, each being one header word followed by nine gain words for taps 0 through 8. A word is accepted on a rising edge where `wr_valid` and `wr_ready` are both 1.
- R3: `wr_ready` falls in the cycle after the 40th word of a profile is accepted. It stays low until a commit, and words offered while it is low are not taken.
- R4: A refresh tick sampled while the shadow is full swaps the banks. In the next cycle, `commit` is high for exactly one cycle, all four sub-channels show the new gains together, and `wr_ready` is 1 again.
- R5: A refresh tick sampled while the shadow is not full leaves the gains unchanged and pulses `underrun` for one cycle. The words already loaded are kept, and loading resumes where it stopped.
- R6: Writing words into the shadow bank never changes the `gains` output.
- R7: A header word whose value differs from the expected sub-channel number (0 to 3) pulses `seq_err` in the cycle after it is accepted. The record is still stored in its slot and is committed normally.
- R8: The gain for sub-channel s, tap t occupies `gains[(s*9+t)*8 +: 8]`.
- R9: After a commit, the next profile loads into the other bank. Successive commits alternate banks, and each one presents exactly the profile loaded since the commit before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Host offers a profile word |
| wr_data | input | 8 | Profile word (header or gain) |
| wr_ready | output | 1 | Shadow bank can take a word |
| refresh_tick | input | 1 | Profile boundary strobe |
| gains | output | 288 | Active-bank tap gains, packed per R8 |
| commit | output | 1 | One-cycle pulse after a bank swap |
| underrun | output | 1 | One-cycle pulse after a tick with an incomplete shadow |
| seq_err | output | 1 | One-cycle pulse after a bad header word |

## Verification
Every result is due exactly one clock edge after its cause:
- the gains, `commit`, `underrun` and the restored `wr_ready` follow the edge that samples the tick;
- `seq_err` follows the edge that accepts the bad header;
- a dropped `wr_ready` follows the edge that takes the 40th word.

The bench drives inputs on the falling edge and samples at the next falling edge, so each check lands on the first cycle in which the result must show. Pulse checks are repeated one cycle later, to confirm that the pulse has already cleared.

// File: rtl/ppl_pkg.sv
// Shared types for the profile loader.
package ppl_pkg;
    // Outcome of a refresh tick.
    typedef enum logic [1:0] {
        SW_IDLE     = 2'd0,
        SW_COMMIT   = 2'd1,
        SW_UNDERRUN = 2'd2
    } swap_dec_e;
endpackage

// File: rtl/ppl_word_seq.sv
// Word sequencer: tracks the position of the next host word inside a profile
// (sub-channel, slot 0 = header, slots 1..TAPS = gains). It checks headers and
// stops taking words once the shadow is full.
// Assumes clear_i is only raised while full.
module ppl_word_seq #(
    parameter int NUM_SUB = 4,
    parameter int TAPS    = 9,
    parameter int WORD_W  = 8,
    localparam int SUB_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
    localparam int TAP_W  = (TAPS > 1) ? $clog2(TAPS) : 1,
    localparam int SLOT_W = $clog2(TAPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              clear_i,
    output logic              wr_ready_o,
    output logic              wr_en_o,
    output logic [SUB_W-1:0]  wr_sub_o,
    output logic [TAP_W-1:0]  wr_tap_o,
    output logic              full_o,
    output logic              seq_err_o
);
    logic [SUB_W-1:0]  sub_q;
    logic [SLOT_W-1:0] slot_q;
    logic              full_q;
    logic              err_q;
    logic              fire;
    logic              last_slot;
    logic              last_sub;
    logic [SLOT_W-1:0] slot_m1;

    // Handshake and position decode.
    always_comb begin
        fire      = wr_valid_i && !full_q;
        last_slot = (slot_q == SLOT_W'(TAPS));
        last_sub  = (sub_q == SUB_W'(NUM_SUB - 1));
        slot_m1   = slot_q - SLOT_W'(1);
    end

    // Advance the slot/sub-channel position on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q  <= '0;
            slot_q <= '0;
            full_q <= 1'b0;
        end else if (clear_i) begin
            sub_q  <= '0;
            slot_q <= '0;
            full_q <= 1'b0;
        end else if (fire) begin
            if (last_slot) begin
                slot_q <= '0;
                if (last_sub) begin
                    sub_q  <= '0;
                    full_q <= 1'b1;
                end else begin
                    sub_q <= sub_q + SUB_W'(1);
                end
            end else begin
                slot_q <= slot_q + SLOT_W'(1);
            end
        end
    end

    // Flag a header word that does not match the expected sub-channel.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= fire && (slot_q == '0) && (wr_data_i != WORD_W'(sub_q));
    end

    assign wr_ready_o = !full_q;
    assign wr_en_o    = fire && (slot_q != '0);
    assign wr_sub_o   = sub_q;
    assign wr_tap_o   = TAP_W'(slot_m1);
    assign full_o     = full_q;
    assign seq_err_o  = err_q;

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !clear_i) |=> full_q);                                   // R3
    AST_LAST_WORD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last_slot && last_sub) |=> (full_q && !wr_ready_o));       // R2
endmodule

// File: rtl/ppl_swap_ctrl.sv
// Swap controller: on a refresh tick, either flips the active bank (the shadow
// is full) or reports an underrun. The commit and underrun outputs are
// registered one-cycle pulses.
module ppl_swap_ctrl
    import ppl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic refresh_i,
    input  logic full_i,
    output logic swap_o,
    output logic act_o,
    output logic commit_o,
    output logic underrun_o
);
    swap_dec_e dec;
    logic      act_q;
    logic      commit_q;
    logic      under_q;

    // Classify the current cycle's tick.
    always_comb begin
        if (!refresh_i)  dec = SW_IDLE;
        else if (full_i) dec = SW_COMMIT;
        else             dec = SW_UNDERRUN;
    end

    // Bank select and outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            commit_q <= 1'b0;
            under_q  <= 1'b0;
        end else begin
            if (dec == SW_COMMIT) act_q <= !act_q;
            commit_q <= (dec == SW_COMMIT);
            under_q  <= (dec == SW_UNDERRUN);
        end
    end

    assign swap_o     = (dec == SW_COMMIT);
    assign act_o      = act_q;
    assign commit_o   = commit_q;
    assign underrun_o = under_q;

    AST_COMMIT_FLIPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (act_q != $past(act_q)));                              // R4
    AST_UNDERRUN_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_i && !full_i) |=> (underrun_o && !commit_o && $stable(act_q))); // R5
endmodule

// File: rtl/ppl_bank_store.sv
// Two coefficient banks. Writes go to the shadow bank (not act_i); the gain
// bus is read from the active bank. Both banks reset to zero.
module ppl_bank_store #(
    parameter int NUM_SUB = 4,
    parameter int TAPS    = 9,
    parameter int WORD_W  = 8,
    localparam int SUB_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
    localparam int TAP_W  = (TAPS > 1) ? $clog2(TAPS) : 1,
    localparam int BUS_W  = NUM_SUB * TAPS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic              wr_en_i,
    input  logic [SUB_W-1:0]  wr_sub_i,
    input  logic [TAP_W-1:0]  wr_tap_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [BUS_W-1:0]  gains_o
);
    logic [WORD_W-1:0] bank_q [2][NUM_SUB][TAPS];

    // Store incoming gain words into the shadow bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < NUM_SUB; s++)
                    for (int t = 0; t < TAPS; t++)
                        bank_q[b][s][t] <= '0;
        end else if (wr_en_i) begin
            bank_q[!act_i][wr_sub_i][wr_tap_i] <= wr_data_i;
        end
    end

    // Pack the active bank onto the gain bus.
    for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
        for (genvar t = 0; t < TAPS; t++) begin : g_tap
            assign gains_o[(s*TAPS+t)*WORD_W +: WORD_W] = bank_q[act_i][s][t];
        end
    end

    AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(act_i) |-> $stable(gains_o));                               // R6
endmodule

// File: rtl/ppl_top.sv
// Double-buffered channel profile loader for a four-sub-channel MIMO filter
// bank. The host fills the shadow bank word by word, and a refresh tick
// commits a complete shadow atomically.
// Assumes refresh_tick is a single-cycle strobe.
module ppl_top #(
    parameter int NUM_SUB = 4,
    parameter int TAPS    = 9,
    parameter int WORD_W  = 8,
    localparam int SUB_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
    localparam int TAP_W  = (TAPS > 1) ? $clog2(TAPS) : 1,
    localparam int BUS_W  = NUM_SUB * TAPS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              refresh_tick,
    output logic [BUS_W-1:0]  gains,
    output logic              commit,
    output logic              underrun,
    output logic              seq_err
);
    logic             swap;
    logic             act;
    logic             full;
    logic             wr_en;
    logic [SUB_W-1:0] wr_sub;
    logic [TAP_W-1:0] wr_tap;

    ppl_word_seq #(.NUM_SUB(NUM_SUB), .TAPS(TAPS), .WORD_W(WORD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
        .clear_i(swap), .wr_ready_o(wr_ready), .wr_en_o(wr_en),
        .wr_sub_o(wr_sub), .wr_tap_o(wr_tap), .full_o(full), .seq_err_o(seq_err)
    );

    ppl_swap_ctrl u_swap (
        .clk(clk), .rst_n(rst_n), .refresh_i(refresh_tick), .full_i(full),
        .swap_o(swap), .act_o(act), .commit_o(commit), .underrun_o(underrun)
    );

    ppl_bank_store #(.NUM_SUB(NUM_SUB), .TAPS(TAPS), .WORD_W(WORD_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .act_i(act), .wr_en_i(wr_en),
        .wr_sub_i(wr_sub), .wr_tap_i(wr_tap), .wr_data_i(wr_data), .gains_o(gains)
    );

    AST_NO_DOUBLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && underrun));                                             // R4
    AST_READY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> wr_ready);                                               // R4
endmodule

// File: tb/ppl_top_test.sv
module ppl_top_test;
    localparam int NS = 4;
    localparam int NT = 9;
    localparam int W  = 8;
    localparam int BW = NS * NT * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          refresh_tick = 1'b0;
    logic          wr_ready;
    logic [BW-1:0] gains;
    logic          commit;
    logic          underrun;
    logic          seq_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [W-1:0]  pg [NS][NT];
    logic [BW-1:0] exp_act = '0;

    always #5 clk = ~clk;

    ppl_top uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .refresh_tick(refresh_tick), .gains(gains),
        .commit(commit), .underrun(underrun), .seq_err(seq_err)
    );

    // Expected gain bus for the pending profile, per the R8 layout.
    function automatic logic [BW-1:0] pack_prof();
        logic [BW-1:0] v = '0;
        for (int s = 0; s < NS; s++)
            for (int t = 0; t < NT; t++)
                v[(s*NT+t)*W +: W] = pg[s][t];
        return v;
    endfunction

    task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rand_prof();
        for (int s = 0; s < NS; s++)
            for (int t = 0; t < NT; t++)
                pg[s][t] = W'($urandom);
    endtask

    // Offer one word for one cycle; return whether it was taken.
    task automatic push(input logic [W-1:0] d, output bit taken, output bit err);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        taken    = wr_ready;
        @(negedge clk);
        wr_valid = 1'b0;
        err      = seq_err;
    endtask

    // Send words first..last-1 of the pending profile (R2 order).
    task automatic load(input int first, input int last, input int bad_sub);
        for (int w = first; w < last; w++) begin
            int s = w / (NT + 1);
            int k = w % (NT + 1);
            logic [W-1:0] d;
            bit tk, er;
            if (k == 0) d = (s == bad_sub) ? W'(s + 5) : W'(s);
            else        d = pg[s][k-1];
            push(d, tk, er);
            chk("R2 word accepted", BW'(tk), BW'(1));
            chk("R7 header flag", BW'(er), BW'((k == 0) && (s == bad_sub)));
            chk("R6 gains untouched by shadow writes", gains, exp_act);
        end
    endtask

    // One-cycle tick; sample at the next falling edge.
    task automatic tick(input bit expect_commit);
        @(negedge clk);
        refresh_tick = 1'b1;
        @(negedge clk);
        refresh_tick = 1'b0;
        if (expect_commit) exp_act = pack_prof();
        chk(expect_commit ? "R4 commit pulse" : "R5 no commit", BW'(commit), BW'(expect_commit));
        chk(expect_commit ? "R4 no underrun" : "R5 underrun pulse", BW'(underrun), BW'(!expect_commit));
        chk(expect_commit ? "R4 new gains" : "R5 gains kept", gains, exp_act);
        if (expect_commit) chk("R4 ready restored", BW'(wr_ready), BW'(1));
        @(negedge clk);
        chk("R4 R5 pulses cleared", BW'({commit, underrun}), BW'(0));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit tk, er;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 gains zero", gains, '0);
        chk("R1 flags", BW'({wr_ready, commit, underrun, seq_err}), BW'(4'b1000));

        // R5: tick with an empty shadow
        tick(1'b0);

        // R2 R3 R4: first full random profile
        rand_prof();
        load(0, 40, -1);
        chk("R3 ready low when full", BW'(wr_ready), BW'(0));
        push(8'hA5, tk, er);
        chk("R3 word refused while full", BW'(tk), BW'(0));
        tick(1'b1);

        // R5: partial profile, tick, then finish loading
        rand_prof();
        load(0, 20, -1);
        tick(1'b0);
        chk("R5 ready still high", BW'(wr_ready), BW'(1));
        load(20, 40, -1);
        tick(1'b1);

        // R7: wrong header on sub-channel 2, still committed
        rand_prof();
        load(0, 40, 2);
        tick(1'b1);

        // R8: directed field-position profile
        for (int s = 0; s < NS; s++)
            for (int t = 0; t < NT; t++)
                pg[s][t] = W'(s * 16 + t);
        load(0, 40, -1);
        tick(1'b1);
        chk("R8 sub3 tap8 field", BW'(gains[(3*NT+8)*W +: W]), BW'(8'h38));
        chk("R8 sub1 tap0 field", BW'(gains[(1*NT+0)*W +: W]), BW'(8'h10));

        // R9: several alternating random profiles, some with a bad first header
        for (int i = 0; i < 4; i++) begin
            rand_prof();
            load(0, 40, (i == 1) ? 0 : -1);
            tick(1'b1);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule